// File: doc/BRIEF.md
# Two-Channel Bitstream Decimation Filter

This block converts the one-bit output of a pair of delta-sigma modulators into 18-bit two's complement PCM words. Each channel supplies one bit per modulator clock. A clock enable, `mod_en`, marks the cycles that carry a bit. Bit 1 counts as +1 and bit 0 as -1. Each channel passes through a five-stage cascaded integrator-comb filter that decimates by 64. The filter result is shifted down to 18 bits and clamped to full scale. Both channels are sampled on the same enable and deliver their words in the same cycle, together with a one-cycle `pcm_valid` pulse.

Frame position comes from an internal phase count of enabled bits. A frame is 64 enabled bits, numbered 0 to 63. The decimated word is taken on bit 63 of each frame. The external `frame_sync` input, sampled only on enabled cycles, marks the bit on which a frame starts. If it arrives while the phase count is already 0, it has no effect. Otherwise it restarts the frame at that bit. The comb history then spans an uneven interval, so the following outputs are flagged through `pcm_settling`.

The flag comes from a two-state machine. State FILL is entered at reset and on a realign. It marks each output it emits as settling and counts those outputs. Transition FILL_DONE moves FILL to RUN on the fifth decimation. Transition REALIGN moves RUN, or FILL itself, back to FILL with the count cleared. Outputs emitted in RUN carry `pcm_settling` low.

Top module: `bitstream_decimator`

## Requirements
- R1: An input bit of 1 is integrated as +1 and a bit of 0 as -1. A channel held at 0 settles to the word -131072 (18'h20000).
- R2: Only cycles with `mod_en` high advance the filter or the frame phase. Bit and `frame_sync` values on other cycles have no effect. One output is produced per 64 enabled bits: when phase bit 63 is accepted at a rising edge, `pcm_valid` is high in the following cycle.
- R3: Each word is floor(y / 2^13) clamped to [-131072, 131071]. Here y is the exact response of a five-stage, length-64 boxcar cascade (the CIC response) over all bits since reset, with earlier bits counting as 0. A channel held at 1 therefore holds 131071 for as long as it stays at 1.
- R4: `frame_sync` high on an enabled bit whose phase is not 0 makes that bit phase 0 of a new frame. On a bit that is already phase 0 it changes nothing. Without `mod_en` it is ignored.
- R5: `pcm_valid` is high for exactly one cycle per output. `pcm_l` and `pcm_r` hold their value between pulses.
- R6: `pcm_settling` is high with the first 5 outputs after reset and with the first 5 outputs after each realign, and low with every later output.
- R7: The left and right channels are filtered independently from their own bits and are updated in the same cycle.
- R8: While reset is asserted, `pcm_valid` is 0 and both words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | High on cycles that carry a modulator bit |
| frame_sync | input | 1 | Marks the enabled bit that starts a frame |
| bit_l | input | 1 | Left modulator bit |
| bit_r | input | 1 | Right modulator bit |
| pcm_l | output | 18 | Left PCM word, two's complement |
| pcm_r | output | 18 | Right PCM word, two's complement |
| pcm_valid | output | 1 | One-cycle pulse when new words appear |
| pcm_settling | output | 1 | High when the current words are still settling |

## Verification
The bench drives the block in several ways: sustained all-zero and all-one inputs, a gapped enable with random bits on the idle cycles, a `frame_sync` on phase 0, and a `frame_sync` in mid-frame. Each output word is compared with a direct convolution against the 316-tap cascade response.

- A wrong bit mapping or a stage delay that is off by one would give a wrong output word.
- Missing saturation would make the word wrap to -131072 during the all-ones run.
- A filter that advanced on idle cycles would pick up the random idle bits, and its output would disagree with the reference.
- A realign that fires on phase 0, or a settle count that is off by one, would show a wrong `pcm_settling` value or a shifted `pcm_valid` pulse.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int DEF_DECIM   = 64;
    localparam int DEF_STAGES  = 5;
    localparam int DEF_OUT_W   = 18;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } bsd_state_e;

endpackage

// File: rtl/bsd_integrators.sv
module bsd_integrators #(
    parameter int STAGES = 5,
    parameter int ACC_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    in_bit,
    output logic signed [ACC_W-1:0] sum_o
);

    localparam logic signed [ACC_W-1:0] UNIT = ACC_W'(1);

    logic signed [ACC_W-1:0] acc_q [STAGES];
    logic signed [ACC_W-1:0] acc_d [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign acc_d[k] = acc_q[k] + (in_bit ? UNIT : -UNIT);
        end else begin : g_next
            assign acc_d[k] = acc_q[k] + acc_d[k-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
            end else if (step_en) begin
                acc_q[k] <= acc_d[k];
            end
        end
    end

    assign sum_o = acc_d[STAGES-1];

endmodule

// File: rtl/bsd_combs.sv
module bsd_combs #(
    parameter int STAGES = 5,
    parameter int ACC_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] in_val,
    output logic signed [ACC_W-1:0] out_val
);

    logic signed [ACC_W-1:0] stage_in  [STAGES];
    logic signed [ACC_W-1:0] stage_out [STAGES];
    logic signed [ACC_W-1:0] dly_q     [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stage_in[k] = in_val;
        end else begin : g_next
            assign stage_in[k] = stage_out[k-1];
        end

        assign stage_out[k] = stage_in[k] - dly_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_q[k] <= '0;
            end else if (load) begin
                dly_q[k] <= stage_in[k];
            end
        end
    end

    assign out_val = stage_out[STAGES-1];

endmodule

// File: rtl/bsd_scaler.sv
module bsd_scaler #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 18,
    parameter int SHIFT = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] in_val,
    output logic        [OUT_W-1:0] word_o
);

    localparam logic signed [ACC_W-1:0] POS_LIM    = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM    = ~POS_LIM;
    localparam logic signed [ACC_W-1:0] POS_THRESH = (POS_LIM + ACC_W'(1)) <<< SHIFT;
    localparam logic        [OUT_W-1:0] POS_WORD   = POS_LIM[OUT_W-1:0];

    logic signed [ACC_W-1:0] shifted;
    logic        [OUT_W-1:0] word_d;
    logic        [OUT_W-1:0] word_q;

    always_comb begin
        shifted = in_val >>> SHIFT;
        if (shifted > POS_LIM) begin
            word_d = POS_LIM[OUT_W-1:0];
        end else if (shifted < NEG_LIM) begin
            word_d = NEG_LIM[OUT_W-1:0];
        end else begin
            word_d = shifted[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

    // R3: a filter value at or beyond positive full scale lands on the top code
    a_r3_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && ($signed($past(in_val)) >= POS_THRESH)) |-> (word_q == POS_WORD));

    // R5: the word only changes when a new sample is loaded
    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));

endmodule

// File: rtl/bsd_sequencer.sv
module bsd_sequencer
    import bsd_pkg::*;
#(
    parameter int DECIM       = 64,
    parameter int SETTLE_OUTS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_en,
    input  logic frame_sync,
    output logic dec_o,
    output logic valid_o,
    output logic settle_o
);

    localparam int PH_W   = $clog2(DECIM);
    localparam int FILL_W = $clog2(SETTLE_OUTS + 1);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(DECIM - 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SETTLE_OUTS - 1);

    bsd_state_e        state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic [PH_W-1:0]   phase_q, pos;
    logic              start_here, realign, dec;
    logic              valid_q, settle_q;

    always_comb begin
        start_here = mod_en && frame_sync;
        realign    = start_here && (phase_q != '0);
        pos        = start_here ? '0 : phase_q;
        dec        = mod_en && (pos == PH_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (mod_en) begin
            phase_q <= (pos == PH_LAST) ? '0 : pos + PH_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_FILL: begin
                if (realign) begin
                    fill_d = '0;
                end else if (dec) begin
                    if (fill_q == FILL_LAST) begin
                        state_d = ST_RUN;
                        fill_d  = '0;
                    end else begin
                        fill_d = fill_q + FILL_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (realign) begin
                    state_d = ST_FILL;
                    fill_d  = '0;
                end
            end
            default: begin
                state_d = ST_FILL;
                fill_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            settle_q <= 1'b1;
        end else begin
            valid_q <= dec;
            if (dec) begin
                settle_q <= (state_q == ST_FILL);
            end
        end
    end

    assign dec_o    = dec;
    assign valid_o  = valid_q;
    assign settle_o = settle_q;

    // R4: a mid-frame restart returns the machine to FILL with an empty count
    a_r4_realign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (state_q == ST_FILL && fill_q == '0));

    // R6: RUN is only entered on a decimation that completes the settle count
    a_r6_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> ($past(dec) && $past(fill_q) == FILL_LAST));

    // R6: an output flagged as settled is only produced from RUN
    a_r6_settled_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !settle_q) |-> ($past(state_q) == ST_RUN));

endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator
    import bsd_pkg::*;
#(
    parameter int DECIM  = DEF_DECIM,
    parameter int STAGES = DEF_STAGES,
    parameter int OUT_W  = DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             frame_sync,
    input  logic             bit_l,
    input  logic             bit_r,
    output logic [OUT_W-1:0] pcm_l,
    output logic [OUT_W-1:0] pcm_r,
    output logic             pcm_valid,
    output logic             pcm_settling
);

    localparam int NUM_CH    = 2;
    localparam int GAIN_BITS = STAGES * $clog2(DECIM);
    localparam int ACC_W     = GAIN_BITS + 2;
    localparam int SHIFT     = GAIN_BITS - (OUT_W - 1);

    logic                    dec;
    logic [NUM_CH-1:0]       ch_bits;
    logic [OUT_W-1:0]        ch_word [NUM_CH];

    assign ch_bits = {bit_r, bit_l};

    bsd_sequencer #(
        .DECIM       (DECIM),
        .SETTLE_OUTS (STAGES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_en     (mod_en),
        .frame_sync (frame_sync),
        .dec_o      (dec),
        .valid_o    (pcm_valid),
        .settle_o   (pcm_settling)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic signed [ACC_W-1:0] integ_sum;
        logic signed [ACC_W-1:0] comb_val;

        bsd_integrators #(
            .STAGES (STAGES),
            .ACC_W  (ACC_W)
        ) u_integ (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (mod_en),
            .in_bit  (ch_bits[ch]),
            .sum_o   (integ_sum)
        );

        bsd_combs #(
            .STAGES (STAGES),
            .ACC_W  (ACC_W)
        ) u_comb (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (dec),
            .in_val  (integ_sum),
            .out_val (comb_val)
        );

        bsd_scaler #(
            .ACC_W (ACC_W),
            .OUT_W (OUT_W),
            .SHIFT (SHIFT)
        ) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (dec),
            .in_val (comb_val),
            .word_o (ch_word[ch])
        );
    end

    assign pcm_l = ch_word[0];
    assign pcm_r = ch_word[1];

    // R5: each output is announced by a single-cycle pulse
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    // R2: a new sample is announced only after an enabled bit
    a_r2_valid_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_valid) |-> $past(mod_en));

endmodule

// File: tb/test_bitstream_decimator.sv
module test_bitstream_decimator;

    localparam int TAPS  = 316;
    localparam int SHIFT = 13;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        frame_sync = 1'b0;
    logic        bit_l = 1'b0;
    logic        bit_r = 1'b0;
    logic [17:0] pcm_l, pcm_r;
    logic        pcm_valid, pcm_settling;

    always #5 clk = ~clk;

    bitstream_decimator i_bitstream_decimator (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_en       (mod_en),
        .frame_sync   (frame_sync),
        .bit_l        (bit_l),
        .bit_r        (bit_r),
        .pcm_l        (pcm_l),
        .pcm_r        (pcm_r),
        .pcm_valid    (pcm_valid),
        .pcm_settling (pcm_settling)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    bit     done     = 1'b0;
    string  tag      = "R8";

    longint h [TAPS];
    longint hist_l [TAPS];
    longint hist_r [TAPS];
    int     m_cnt  = 0;
    int     m_fill = 0;
    logic        exp_valid = 1'b0;
    logic        exp_settle = 1'b0;
    logic [17:0] exp_l = '0;
    logic [17:0] exp_r = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic void build_taps();
        longint tmp [TAPS];
        int len = 1;
        for (int i = 0; i < TAPS; i++) h[i] = 0;
        h[0] = 1;
        for (int s = 0; s < 5; s++) begin
            for (int i = 0; i < TAPS; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < 64; j++) begin
                    if (i - j >= 0 && i - j < len) tmp[i] += h[i-j];
                end
            end
            len += 63;
            for (int i = 0; i < TAPS; i++) h[i] = tmp[i];
        end
    endfunction

    function automatic logic [17:0] to_word(input longint y);
        longint s = y >>> SHIFT;
        if (s > 131071) s = 131071;
        if (s < -131072) s = -131072;
        return s[17:0];
    endfunction

    function automatic longint filt_l();
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) acc += h[k] * hist_l[k];
        return acc;
    endfunction

    function automatic longint filt_r();
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) acc += h[k] * hist_r[k];
        return acc;
    endfunction

    task automatic model(input logic en, input logic fs, input logic bl, input logic br);
        int pos;
        exp_valid = 1'b0;
        if (en) begin
            pos = fs ? 0 : m_cnt;
            if (fs && m_cnt != 0) m_fill = 0;
            for (int i = TAPS - 1; i > 0; i--) begin
                hist_l[i] = hist_l[i-1];
                hist_r[i] = hist_r[i-1];
            end
            hist_l[0] = bl ? 1 : -1;
            hist_r[0] = br ? 1 : -1;
            if (pos == 63) begin
                exp_valid  = 1'b1;
                exp_settle = (m_fill < 5);
                if (m_fill < 5) m_fill++;
                exp_l = to_word(filt_l());
                exp_r = to_word(filt_r());
            end
            m_cnt = (pos + 1) % 64;
        end
    endtask

    task automatic check_outputs();
        check(pcm_valid === exp_valid, {"R5 R2 ", tag}, longint'(pcm_valid), longint'(exp_valid));
        if (exp_valid)
            check(pcm_settling === exp_settle, {"R6 ", tag}, longint'(pcm_settling), longint'(exp_settle));
        if (!exp_settle) begin
            check(pcm_l === exp_l, {"R3 R7 left ", tag}, longint'($signed(pcm_l)), longint'($signed(exp_l)));
            check(pcm_r === exp_r, {"R3 R7 right ", tag}, longint'($signed(pcm_r)), longint'($signed(exp_r)));
        end
    endtask

    task automatic step(input logic en, input logic fs, input logic bl, input logic br);
        @(negedge clk);
        check_outputs();
        mod_en = en;
        frame_sync = fs;
        bit_l = bl;
        bit_r = br;
        model(en, fs, bl, br);
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    initial begin
        #(WD_CYCLES * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        build_taps();
        for (int i = 0; i < TAPS; i++) begin
            hist_l[i] = 0;
            hist_r[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        check(pcm_valid === 1'b0, "R8 valid", longint'(pcm_valid), 0);
        check(pcm_l === 18'd0, "R8 left", longint'(pcm_l), 0);
        check(pcm_r === 18'd0, "R8 right", longint'(pcm_r), 0);
        rst_n = 1'b1;

        // R1: all-zero input
        tag = "R1";
        for (int i = 0; i < 768; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check(pcm_l === 18'h20000, "R1 left full negative", longint'($signed(pcm_l)), -131072);
        check(pcm_r === 18'h20000, "R1 right full negative", longint'($signed(pcm_r)), -131072);

        // R3: all-one input clamps to the top code
        tag = "R3 clamp";
        for (int i = 0; i < 768; i++) step(1'b1, 1'b0, 1'b1, 1'b1);
        check(pcm_l === 18'd131071, "R3 left clamp", longint'($signed(pcm_l)), 131071);
        check(pcm_r === 18'd131071, "R3 right clamp", longint'($signed(pcm_r)), 131071);

        // R7: independent channels
        tag = "R7";
        for (int i = 0; i < 640; i++) step(1'b1, 1'b0, i[0], next_rand());

        // R2: gapped enable with noise on idle cycles
        tag = "R2 gapped";
        for (int i = 0; i < 1920; i++) begin
            logic a = next_rand();
            logic b = next_rand();
            step(i % 3 == 0, next_rand(), a, b);
        end

        // R4: sync on phase 0 changes nothing
        tag = "R4 aligned";
        for (int i = 0; i < 256; i++) step(1'b1, m_cnt == 0, (i % 5) < 3, next_rand());

        // R4: sync without enable ignored, then a mid-frame restart (R6)
        tag = "R4 R6 realign";
        while (m_cnt != 20) step(1'b1, 1'b0, next_rand(), 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, next_rand(), 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 700; i++) step(1'b1, 1'b0, (i % 7) < 5, (i % 3) != 0);

        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule